// File: doc/BRIEF.md
# Interrogation Pulse Decoder

This block sits behind a threshold detector in an interrogation receiver. Each cycle it gets one bit that says a pulse is present. It also gets a level flag that tells a strong, main-level pulse from a weaker, control-level one. It finds the leading and trailing edge of every pulse and counts its width in clock cycles. It timestamps each leading edge against a free-running counter. It then picks out the first pulse (P1), the optional control pulse (P2) and the closing main-level pulse (P3) of an interrogation.

The interrogation mode comes from the lead-to-lead spacing between P1 and P3. That spacing is matched against a five-entry table with a tolerance window on each entry. The result is either a one-cycle mode strobe with a mode code, or a one-cycle error strobe with a cause. The possible causes are a pulse of wrong width, a spacing that matches no table entry, and no closing pulse within the allowed time. All timing constants are counted in clock cycles and are derived from a cycles-per-microsecond parameter, which defaults to 100.

Top module: `interrog_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, mode_valid and err_valid are low.
- R2: The width of a pulse is the number of consecutive cycles in which pulse_in is sampled high. A pulse is accepted when its width is between 70 and 90 cycles, both limits included.
- R3: The P1-to-P3 spacing is counted in cycles from leading edge to leading edge. Each table entry accepts its nominal value ±10 cycles, both limits included. Spacing 300 gives mode_code 0 (mode 1), 500 gives 1 (mode 2), 800 gives 2 (mode 3/A), 2100 gives 3 (mode C) and 2500 gives 4 (mode D).
- R4: A pulse with main_lvl low at its leading edge is a control-level pulse. If its width is acceptable, it is never taken as P1 or P3 and produces no output.
- R5: In idle, only a main-level pulse of acceptable width starts a search as P1. A control-level pulse that comes first leaves the decoder idle.
- R6: Let edge k be the first clock edge at which pulse_in is sampled low after P3. mode_valid is high for exactly the one cycle that follows edge k. Every err_valid strobe follows the same timing relative to the pulse end or event that causes it.
- R7: Suppose P1's leading edge is sampled at edge e and no main-level pulse has ended since. If no pulse is in progress at edge e+2600, err_valid rises after that edge with err_code 1 (timeout), and the decoder returns to idle. A pulse still in progress at edge e+2600 holds the timeout off.
- R8: A main-level pulse of acceptable width that ends while a search is open, with a spacing outside every table window, gives err_code 2 (unknown spacing) and returns the decoder to idle. This includes a main-level pulse sent at the P2 position.
- R9: Any pulse, of either level, whose width is outside 70 to 90 cycles gives err_code 3 (bad width) when it ends. It also returns the decoder to idle, so the next main-level pulse is a fresh P1 candidate.
- R10: mode_valid and err_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Thresholded pulse-present sample |
| main_lvl | input | 1 | 1 = main level, 0 = control level, taken at the leading edge |
| mode_valid | output | 1 | One-cycle strobe: a mode was decoded |
| mode_code | output | 3 | Decoded mode, 0..4, valid with mode_valid |
| err_valid | output | 1 | One-cycle strobe: the search failed |
| err_code | output | 2 | 1 timeout, 2 unknown spacing, 3 bad width |

## Verification
Every result appears right after the clock edge that ends the event causing it. A mode strobe or a width or spacing error comes in the cycle after pulse_in is first sampled low at the end of the deciding pulse. A timeout comes in the cycle after the edge 2600 cycles past P1's leading edge. The bench counts clock edges from the moment it starts driving a burst and records the edge count at which each strobe is seen. It compares that count, the number of strobes and the code against an expected edge number computed from the pulse positions it drove. Table boundaries (±10 and ±11 cycles), width limits, a mode-D pulse that is still high at the timeout edge, and control-level pulses in both idle and search are driven as directed cases. These are mixed with seeded random bursts.

// File: rtl/idc_pkg.sv
package idc_pkg;

    localparam int TS_W    = 16;
    localparam int N_MODES = 5;

    typedef enum logic [2:0] {
        MODE_1  = 3'd0,
        MODE_2  = 3'd1,
        MODE_3A = 3'd2,
        MODE_C  = 3'd3,
        MODE_D  = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_SPACING = 2'd2,
        ERR_WIDTH   = 2'd3
    } err_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        logic            lvl_main;
        logic [TS_W-1:0] width;
        logic [TS_W-1:0] lead_ts;
    } pulse_rec_t;

    // Nominal P1-to-P3 spacing of table entry idx, in microseconds
    function automatic int mode_space_us(input int idx);
        case (idx)
            0:       return 3;
            1:       return 5;
            2:       return 8;
            3:       return 21;
            default: return 25;
        endcase
    endfunction

    function automatic logic in_window(input logic [TS_W-1:0] v, input int nom, input int tol);
        int val;
        val = int'(v);
        return (val + tol >= nom) && (val <= nom + tol);
    endfunction

endpackage

// File: rtl/idc_pulse_meter.sv
module idc_pulse_meter
    import idc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                pulse_in,
    input  logic                main_lvl,
    output logic                done,
    output logic                busy,
    output logic [TS_W-1:0]     now_ts,
    output pulse_rec_t          rec
);

    logic            prev_q;
    logic [TS_W-1:0] now_q;
    logic [TS_W-1:0] width_q;
    logic [TS_W-1:0] lead_q;
    logic            lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            now_q   <= '0;
            width_q <= '0;
            lead_q  <= '0;
            lvl_q   <= 1'b0;
        end else begin
            now_q  <= now_q + 1'b1;
            prev_q <= pulse_in;
            if (pulse_in && !prev_q) begin
                width_q <= {{(TS_W-1){1'b0}}, 1'b1};
                lead_q  <= now_q;
                lvl_q   <= main_lvl;
            end else if (pulse_in && (width_q != '1)) begin
                width_q <= width_q + 1'b1;
            end
        end
    end

    assign done   = prev_q && !pulse_in;
    assign busy   = prev_q || pulse_in;
    assign now_ts = now_q;
    assign rec    = '{lvl_main: lvl_q, width: width_q, lead_ts: lead_q};

    // R2: a fresh leading edge restarts the width count at one
    assert_lead_count_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse_in && !$past(pulse_in) && !$past(rst)) |=> (rec.width == 1));

    // R5: level is captured from the leading-edge sample
    assert_lvl_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (pulse_in && !$past(pulse_in) && !$past(rst)) |=> (rec.lvl_main == $past(main_lvl)));

endmodule

// File: rtl/idc_mode_table.sv
module idc_mode_table
    import idc_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int SPACE_TOL  = 10
) (
    input  logic [TS_W-1:0] spacing,
    output logic            hit,
    output logic [2:0]      mode_idx
);

    logic [N_MODES-1:0] hit_vec;

    for (genvar i = 0; i < N_MODES; i++) begin : g_entry
        localparam int NOM = mode_space_us(i) * CYC_PER_US;
        assign hit_vec[i] = in_window(spacing, NOM, SPACE_TOL);
    end

    always_comb begin
        mode_idx = 3'd0;
        for (int i = N_MODES - 1; i >= 0; i--) begin
            if (hit_vec[i]) mode_idx = 3'(i);
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/idc_sequencer.sv
module idc_sequencer
    import idc_pkg::*;
#(
    parameter int WIDTH_NOM = 80,
    parameter int WIDTH_TOL = 10,
    parameter int TIMEOUT   = 2600
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            done,
    input  logic            busy,
    input  logic [TS_W-1:0] now_ts,
    input  pulse_rec_t      rec,
    input  logic            tbl_hit,
    input  logic [2:0]      tbl_mode,
    output logic [TS_W-1:0] spacing,
    output logic            mode_valid,
    output logic [2:0]      mode_code,
    output logic            err_valid,
    output logic [1:0]      err_code
);

    state_e          state_q;
    logic [TS_W-1:0] p1_ts_q;
    logic [TS_W-1:0] elapsed;
    logic            width_ok;
    logic            timed_out;
    err_e            err_q;

    assign spacing   = rec.lead_ts - p1_ts_q;
    assign elapsed   = now_ts - p1_ts_q;
    assign width_ok  = in_window(rec.width, WIDTH_NOM, WIDTH_TOL);
    assign timed_out = (state_q == ST_WAIT) && !busy && (int'(elapsed) >= TIMEOUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            p1_ts_q    <= '0;
            mode_valid <= 1'b0;
            mode_code  <= 3'd0;
            err_valid  <= 1'b0;
            err_q      <= ERR_NONE;
        end else begin
            mode_valid <= 1'b0;
            err_valid  <= 1'b0;
            if (done) begin
                if (!width_ok) begin
                    err_valid <= 1'b1;
                    err_q     <= ERR_WIDTH;
                    state_q   <= ST_IDLE;
                end else if (rec.lvl_main) begin
                    if (state_q == ST_IDLE) begin
                        p1_ts_q <= rec.lead_ts;
                        state_q <= ST_WAIT;
                    end else begin
                        if (tbl_hit) begin
                            mode_valid <= 1'b1;
                            mode_code  <= tbl_mode;
                        end else begin
                            err_valid <= 1'b1;
                            err_q     <= ERR_SPACING;
                        end
                        state_q <= ST_IDLE;
                    end
                end
            end else if (timed_out) begin
                err_valid <= 1'b1;
                err_q     <= ERR_TIMEOUT;
                state_q   <= ST_IDLE;
            end
        end
    end

    assign err_code = err_q;

    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(mode_valid && err_valid));

    assert_single_R6: assert property (@(posedge clk) disable iff (rst)
        mode_valid |=> !mode_valid);

    assert_mode_after_end_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_valid && !$past(rst)) |-> $past(done));

    assert_code_range_R3: assert property (@(posedge clk) disable iff (rst)
        mode_valid |-> (int'(mode_code) < N_MODES));

    assert_timeout_src_R7: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_code == ERR_TIMEOUT && !$past(rst))
            |-> ($past(state_q) == ST_WAIT && !$past(busy)));

endmodule

// File: rtl/interrog_decoder.sv
module interrog_decoder
    import idc_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int TOL_CYC    = 10,
    parameter int TIMEOUT    = 2600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pulse_in,
    input  logic       main_lvl,
    output logic       mode_valid,
    output logic [2:0] mode_code,
    output logic       err_valid,
    output logic [1:0] err_code
);

    localparam int WIDTH_NOM = (8 * CYC_PER_US) / 10;

    logic            done;
    logic            busy;
    logic [TS_W-1:0] now_ts;
    pulse_rec_t      rec;
    logic [TS_W-1:0] spacing;
    logic            tbl_hit;
    logic [2:0]      tbl_mode;

    idc_pulse_meter i_meter (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (pulse_in),
        .main_lvl (main_lvl),
        .done     (done),
        .busy     (busy),
        .now_ts   (now_ts),
        .rec      (rec)
    );

    idc_mode_table #(
        .CYC_PER_US (CYC_PER_US),
        .SPACE_TOL  (TOL_CYC)
    ) i_table (
        .spacing  (spacing),
        .hit      (tbl_hit),
        .mode_idx (tbl_mode)
    );

    idc_sequencer #(
        .WIDTH_NOM (WIDTH_NOM),
        .WIDTH_TOL (TOL_CYC),
        .TIMEOUT   (TIMEOUT)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .busy       (busy),
        .now_ts     (now_ts),
        .rec        (rec),
        .tbl_hit    (tbl_hit),
        .tbl_mode   (tbl_mode),
        .spacing    (spacing),
        .mode_valid (mode_valid),
        .mode_code  (mode_code),
        .err_valid  (err_valid),
        .err_code   (err_code)
    );

    // R6: a decoded mode follows a falling edge of the pulse input by one cycle
    assert_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_valid && !$past(rst) && !$past(rst, 2))
            |-> (!$past(pulse_in) && $past(pulse_in, 2)));

endmodule

// File: tb/test_interrog_decoder.sv
module test_interrog_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_in = 1'b0;
    logic       main_lvl = 1'b1;
    logic       mode_valid;
    logic [2:0] mode_code;
    logic       err_valid;
    logic [1:0] err_code;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int ev_n     = 0;
    int ev_err   = 0;
    int ev_code  = 0;
    int ev_cyc   = 0;
    int both_seen = 0;
    int t0       = 0;

    interrog_decoder i_interrog_decoder (
        .clk        (clk),
        .rst        (rst),
        .pulse_in   (pulse_in),
        .main_lvl   (main_lvl),
        .mode_valid (mode_valid),
        .mode_code  (mode_code),
        .err_valid  (err_valid),
        .err_code   (err_code)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (mode_valid && err_valid) both_seen++;
            if (mode_valid) begin
                ev_n++; ev_err = 0; ev_code = int'(mode_code); ev_cyc = cyc;
            end
            if (err_valid) begin
                ev_n++; ev_err = 1; ev_code = int'(err_code); ev_cyc = cyc;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mode(input int s);
        int noms[5] = '{300, 500, 800, 2100, 2500};
        for (int i = 0; i < 5; i++)
            if (s >= noms[i] - 10 && s <= noms[i] + 10) return i;
        return -1;
    endfunction

    // p3_lvl: 1 main, 0 control; s3 = 0 means no third pulse
    task automatic burst(input int w1, input bit lvl1, input int p2w,
                         input int s3, input int w3, input bit p3_lvl, input int tail);
        int len;
        len = w1;
        if (p2w > 0 && 200 + p2w > len) len = 200 + p2w;
        if (s3 > 0 && s3 + w3 > len) len = s3 + w3;
        len = len + tail;
        @(negedge clk);
        ev_n = 0;
        t0 = cyc;
        for (int c = 0; c < len; c++) begin
            bit in1, in2, in3;
            in1 = (c < w1);
            in2 = (p2w > 0) && (c >= 200) && (c < 200 + p2w);
            in3 = (s3 > 0) && (c >= s3) && (c < s3 + w3);
            pulse_in = in1 | in2 | in3;
            main_lvl = in2 ? 1'b0 : (in3 ? p3_lvl : (in1 ? lvl1 : 1'b1));
            @(negedge clk);
        end
        pulse_in = 1'b0;
        main_lvl = 1'b1;
    endtask

    task automatic expect_one(input string req, input int err, input int code, input int at);
        check(ev_n == 1, {req, " strobe count"}, ev_n, 1);
        check(ev_err == err, {req, " strobe kind"}, ev_err, err);
        check(ev_code == code, {req, " code"}, ev_code, code);
        check(ev_cyc == at, {req, " cycle"}, ev_cyc - t0, at - t0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        check(mode_valid == 1'b0 && err_valid == 1'b0, "R1 in reset", int'(mode_valid | err_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mode_valid == 1'b0 && err_valid == 1'b0, "R1 after reset", int'(mode_valid | err_valid), 0);

        // R3 R6: mode 1 nominal
        burst(80, 1, 0, 300, 80, 1, 20);
        expect_one("R3 R6 mode1", 0, 0, t0 + 1 + 380);
        // R2 R4: width limits 70 and 90, control P2 ignored
        burst(70, 1, 75, 500, 90, 1, 20);
        expect_one("R2 R4 mode2 with P2", 0, 1, t0 + 1 + 590);
        burst(80, 1, 0, 800, 80, 1, 20);
        expect_one("R3 mode3A", 0, 2, t0 + 1 + 880);
        burst(80, 1, 0, 2100, 80, 1, 20);
        expect_one("R3 modeC", 0, 3, t0 + 1 + 2180);
        // R3 R7: mode D still high at the timeout edge
        burst(80, 1, 0, 2510, 90, 1, 20);
        expect_one("R3 R7 modeD at window edge", 0, 4, t0 + 1 + 2600);
        // R3 window limits
        burst(80, 1, 0, 290, 80, 1, 20);
        expect_one("R3 low limit", 0, 0, t0 + 1 + 370);
        burst(80, 1, 0, 310, 80, 1, 20);
        expect_one("R3 high limit", 0, 0, t0 + 1 + 390);
        // R8: just outside windows
        burst(80, 1, 0, 311, 80, 1, 20);
        expect_one("R8 spacing 311", 1, 2, t0 + 1 + 391);
        burst(80, 1, 0, 489, 80, 1, 20);
        expect_one("R8 spacing 489", 1, 2, t0 + 1 + 569);
        // R8: main-level pulse at the P2 slot is not a control pulse
        burst(80, 1, 0, 200, 80, 1, 20);
        expect_one("R8 main at P2 slot", 1, 2, t0 + 1 + 280);
        // R9 R2: bad widths
        burst(69, 1, 0, 0, 0, 1, 20);
        expect_one("R9 width 69", 1, 3, t0 + 1 + 69);
        burst(91, 1, 0, 0, 0, 1, 20);
        expect_one("R9 width 91", 1, 3, t0 + 1 + 91);
        burst(80, 1, 0, 500, 95, 1, 20);
        expect_one("R9 bad P3 width", 1, 3, t0 + 1 + 595);
        burst(80, 1, 0, 500, 80, 1, 20);
        expect_one("R9 search restarts", 0, 1, t0 + 1 + 580);
        // R4: control pulse alone in idle
        burst(80, 0, 0, 0, 0, 1, 30);
        check(ev_n == 0, "R4 control pulse in idle", ev_n, 0);
        // R4 R7: control pulse at P3 slot, then timeout
        burst(80, 1, 0, 300, 80, 0, 2540);
        expect_one("R4 R7 control at P3 slot", 1, 1, t0 + 1 + 2600);
        // R7: P1 alone
        burst(80, 1, 0, 0, 0, 1, 2560);
        expect_one("R7 timeout", 1, 1, t0 + 1 + 2600);
        // R5: control first, main pulse at 300 becomes P1
        burst(80, 0, 0, 300, 80, 1, 2560);
        expect_one("R5 main pulse becomes P1", 1, 1, t0 + 1 + 300 + 2600);

        // seeded random bursts
        void'($urandom(32'd4711));
        for (int it = 0; it < 30; it++) begin
            int r, s, w1, w3, p2w, em;
            int noms[5] = '{300, 500, 800, 2100, 2500};
            r   = int'($urandom_range(0, 5));
            w1  = int'($urandom_range(70, 90));
            w3  = int'($urandom_range(70, 90));
            p2w = ($urandom_range(0, 1) == 1) ? int'($urandom_range(70, 80)) : 0;
            if (r < 5) s = noms[r] + int'($urandom_range(0, 20)) - 10;
            else       s = 1200 + int'($urandom_range(0, 200));
            em = exp_mode(s);
            burst(w1, 1, p2w, s, w3, 1, 20);
            if (em >= 0) expect_one("R3 R6 random mode", 0, em, t0 + 1 + s + w3);
            else         expect_one("R8 random spacing", 1, 2, t0 + 1 + s + w3);
        end

        check(both_seen == 0, "R10 exclusive strobes", both_seen, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R6 actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule